// File: doc/BRIEF.md
# Pulse-Swallow Programmable Divider

This block holds the digital counters of a frequency synthesizer. It divides the oscillator side by a total ratio N = P·M + A, where P is the base modulus of a dual-modulus P/(P+1) prescaler. A main counter M counts prescaler cycles. A swallow counter A keeps the prescaler at P+1 for the first A of those cycles. Separately, a reference counter divides the reference side by R to give the comparison rate. Each divider emits a one-cycle pulse when its count completes and then reloads.

The block runs in a single clock domain. Each oscillator edge arrives as a one-cycle `vcoTick` enable, and each reference edge arrives as a `refTick` enable. New M, A and R values are written through a small configuration port. A valid write is held as a pending setting, and each divider takes it up only at its next terminal count, so a running division cycle is never cut short. A write with A greater than M, or with M equal to zero, is rejected and raises an error flag.

Top module: `pswDivTop`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, `vcoPulse`, `refPulse` and `cfgError` are 0. The dividers start from the default settings.
- R2: Between consecutive `vcoPulse` assertions, exactly 64·M + A cycles with `vcoTick`=1 occur, where M and A are the settings in force. The prescaler divides by 65 for the first A prescaler cycles and by 64 for the remaining M − A.
- R3: `vcoPulse` is high for exactly one cycle. That cycle is the one after the clock edge at which the completing `vcoTick` was sampled.
- R4: Cycles with `vcoTick`=0 do not advance the oscillator divider, and cycles with `refTick`=0 do not advance the reference divider.
- R5: A write (`cfgWrite`=1) with `cfgA` > `cfgM`, or with `cfgM` = 0, sets `cfgError` to 1 from the next cycle. Such a write leaves M, A and R unchanged.
- R6: A valid write clears `cfgError` from the next cycle. Its values take effect only when each divider next reloads. A write in the same cycle as a terminal count takes effect at the terminal count after that.
- R7: Between consecutive `refPulse` assertions, exactly R cycles with `refTick`=1 occur. The pulse appears the cycle after the completing tick.
- R8: An R value of 0 or 1 divides by 1: every `refTick` produces a `refPulse` in the next cycle.
- R9: The defaults after reset are M=63, A=12 and R=16, which gives N = 4044.
- R10: The boundary settings A = M (every prescaler cycle is P+1) and A = 0 (every prescaler cycle is P) give 65·M and 64·M ticks respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| vcoTick | input | 1 | One oscillator edge to count |
| refTick | input | 1 | One reference edge to count |
| cfgWrite | input | 1 | Write strobe for the settings |
| cfgM | input | 10 | Main counter value M |
| cfgA | input | 6 | Swallow counter value A |
| cfgR | input | 10 | Reference divisor R |
| vcoPulse | output | 1 | One-cycle pulse per N oscillator ticks |
| refPulse | output | 1 | One-cycle pulse per R reference ticks |
| cfgError | output | 1 | Last write was rejected |

## Verification
The hardest case to reach is a settings write that lands in the very cycle a divider reloads. That write must be held over for one more full period, and with the default N of 4044 it almost never lines up by chance. The random phase therefore uses small M values, frequent writes and sparse ticks, so that writes collide with terminal counts many times. A reference model in the bench tracks the remaining ticks and the pending settings on each side separately, so every such collision is checked cycle by cycle.

// File: rtl/pswDivPkg.sv
package pswDivPkg;

  typedef struct packed {
    logic presAdvance;  // count one oscillator tick in the prescaler
    logic modStep;      // prescaler wrapped, M and A step down
    logic vcoReload;    // terminal count, reload M/A and clear prescaler
    logic refStep;      // reference counter steps down
    logic refReload;    // reference terminal count, reload R
  } divStrobes_t;

  // R of 0 or 1 both mean divide-by-1
  function automatic logic [15:0] effDiv(input logic [15:0] r);
    return (r < 16'd2) ? 16'd1 : r;
  endfunction

endpackage

// File: rtl/pswDivData.sv
module pswDivData
  import pswDivPkg::*;
#(
  parameter int P     = 64,
  parameter int MW    = 10,
  parameter int AW    = 6,
  parameter int RW    = 10,
  parameter int DEF_M = 63,
  parameter int DEF_A = 12,
  parameter int DEF_R = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  divStrobes_t   strobes,
  input  logic [MW-1:0] loadM,
  input  logic [AW-1:0] loadA,
  input  logic [RW-1:0] loadR,
  output logic          presWrap,
  output logic          mLast,
  output logic          rLast
);
  localparam int PW = $clog2(P + 1);
  localparam logic [PW-1:0] LAST_LO = PW'(P - 1);
  localparam logic [PW-1:0] LAST_HI = PW'(P);
  localparam logic [15:0] DEF_R_EFF = effDiv(16'(DEF_R));

  logic [PW-1:0] presCnt;
  logic [MW-1:0] mCnt;
  logic [AW-1:0] aCnt;
  logic [RW-1:0] rCnt;
  logic          swallowing;

  assign swallowing = (aCnt != '0);
  assign presWrap   = (presCnt == (swallowing ? LAST_HI : LAST_LO));
  assign mLast      = (mCnt == MW'(1));
  assign rLast      = (rCnt == RW'(1));

  // oscillator side: prescaler plus M and A counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presCnt <= '0;
      mCnt    <= MW'(DEF_M);
      aCnt    <= AW'(DEF_A);
    end else if (strobes.vcoReload) begin
      presCnt <= '0;
      mCnt    <= loadM;
      aCnt    <= loadA;
    end else if (strobes.modStep) begin
      presCnt <= '0;
      mCnt    <= mCnt - MW'(1);
      if (swallowing) aCnt <= aCnt - AW'(1);
    end else if (strobes.presAdvance) begin
      presCnt <= presCnt + PW'(1);
    end
  end

  // reference side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rCnt <= RW'(DEF_R_EFF);
    end else if (strobes.refReload) begin
      rCnt <= RW'(effDiv(16'(loadR)));
    end else if (strobes.refStep) begin
      rCnt <= rCnt - RW'(1);
    end
  end
endmodule

// File: rtl/pswDivCtrl.sv
module pswDivCtrl
  import pswDivPkg::*;
#(
  parameter int MW    = 10,
  parameter int AW    = 6,
  parameter int RW    = 10,
  parameter int DEF_M = 63,
  parameter int DEF_A = 12,
  parameter int DEF_R = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          vcoTick,
  input  logic          refTick,
  input  logic          cfgWrite,
  input  logic [MW-1:0] cfgM,
  input  logic [AW-1:0] cfgA,
  input  logic [RW-1:0] cfgR,
  input  logic          presWrap,
  input  logic          mLast,
  input  logic          rLast,
  output divStrobes_t   strobes,
  output logic [MW-1:0] loadM,
  output logic [AW-1:0] loadA,
  output logic [RW-1:0] loadR,
  output logic          vcoPulse,
  output logic          refPulse,
  output logic          cfgError
);
  logic [MW-1:0] pendM;
  logic [AW-1:0] pendA;
  logic [RW-1:0] pendR;
  logic          cfgOk;

  // swallow count may not exceed the main count, main count at least 1
  assign cfgOk = (cfgM != '0) && (MW'(cfgA) <= cfgM);

  always_comb begin
    strobes             = '0;
    strobes.presAdvance = vcoTick;
    strobes.modStep     = vcoTick & presWrap & ~mLast;
    strobes.vcoReload   = vcoTick & presWrap & mLast;
    strobes.refStep     = refTick & ~rLast;
    strobes.refReload   = refTick & rLast;
  end

  assign loadM = pendM;
  assign loadA = pendA;
  assign loadR = pendR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendM    <= MW'(DEF_M);
      pendA    <= AW'(DEF_A);
      pendR    <= RW'(DEF_R);
      cfgError <= 1'b0;
    end else if (cfgWrite) begin
      cfgError <= ~cfgOk;
      if (cfgOk) begin
        pendM <= cfgM;
        pendA <= cfgA;
        pendR <= cfgR;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vcoPulse <= 1'b0;
      refPulse <= 1'b0;
    end else begin
      vcoPulse <= strobes.vcoReload;
      refPulse <= strobes.refReload;
    end
  end
endmodule

// File: rtl/pswDivTop.sv
module pswDivTop
  import pswDivPkg::*;
#(
  parameter int P     = 64,
  parameter int MW    = 10,
  parameter int AW    = $clog2(P),
  parameter int RW    = 10,
  parameter int DEF_M = 63,
  parameter int DEF_A = 12,
  parameter int DEF_R = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          vcoTick,
  input  logic          refTick,
  input  logic          cfgWrite,
  input  logic [MW-1:0] cfgM,
  input  logic [AW-1:0] cfgA,
  input  logic [RW-1:0] cfgR,
  output logic          vcoPulse,
  output logic          refPulse,
  output logic          cfgError
);
  divStrobes_t   strobes;
  logic [MW-1:0] loadM;
  logic [AW-1:0] loadA;
  logic [RW-1:0] loadR;
  logic          presWrap, mLast, rLast;

  pswDivCtrl #(
    .MW(MW), .AW(AW), .RW(RW),
    .DEF_M(DEF_M), .DEF_A(DEF_A), .DEF_R(DEF_R)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .vcoTick(vcoTick), .refTick(refTick),
    .cfgWrite(cfgWrite), .cfgM(cfgM), .cfgA(cfgA), .cfgR(cfgR),
    .presWrap(presWrap), .mLast(mLast), .rLast(rLast),
    .strobes(strobes),
    .loadM(loadM), .loadA(loadA), .loadR(loadR),
    .vcoPulse(vcoPulse), .refPulse(refPulse), .cfgError(cfgError)
  );

  pswDivData #(
    .P(P), .MW(MW), .AW(AW), .RW(RW),
    .DEF_M(DEF_M), .DEF_A(DEF_A), .DEF_R(DEF_R)
  ) u_data (
    .clk(clk), .rstN(rstN),
    .strobes(strobes),
    .loadM(loadM), .loadA(loadA), .loadR(loadR),
    .presWrap(presWrap), .mLast(mLast), .rLast(rLast)
  );
endmodule

// File: rtl/pswDivChk.sv
module pswDivChk #(
  parameter int P  = 64,
  parameter int MW = 10,
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rstN,
  input logic          vcoTick,
  input logic          refTick,
  input logic          cfgWrite,
  input logic [MW-1:0] cfgM,
  input logic [AW-1:0] cfgA,
  input logic          vcoPulse,
  input logic          refPulse,
  input logic          cfgError
);
  logic [15:0] gapCnt;
  logic        badCfg;

  assign badCfg = (cfgM == '0) || (MW'(cfgA) > cfgM);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               gapCnt <= '0;
    else if (vcoPulse)       gapCnt <= '0;
    else if (gapCnt != '1)   gapCnt <= gapCnt + 16'd1;
  end

  // R3: a pulse lasts one cycle and follows a sampled tick
  a_r3_vco_single: assert property (@(posedge clk) disable iff (!rstN)
    vcoPulse |=> !vcoPulse);
  a_r3_vco_after_tick: assert property (@(posedge clk) disable iff (!rstN)
    vcoPulse |-> $past(vcoTick));
  // R2: at least P ticks, hence P cycles, separate oscillator pulses
  a_r2_vco_spacing: assert property (@(posedge clk) disable iff (!rstN)
    vcoPulse |-> (gapCnt >= 16'(P - 1)));
  // R7: reference pulse only follows a reference tick
  a_r7_ref_after_tick: assert property (@(posedge clk) disable iff (!rstN)
    refPulse |-> $past(refTick));
  // R5: a rejected write raises the flag
  a_r5_err_set: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrite && badCfg) |=> cfgError);
  // R6: an accepted write clears the flag
  a_r6_err_clear: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrite && !badCfg) |=> !cfgError);
  // R5: the flag only moves on a write
  a_r5_err_hold: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrite |=> $stable(cfgError));
endmodule

bind pswDivTop pswDivChk #(.P(P), .MW(MW), .AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .vcoTick(vcoTick), .refTick(refTick),
  .cfgWrite(cfgWrite), .cfgM(cfgM), .cfgA(cfgA),
  .vcoPulse(vcoPulse), .refPulse(refPulse), .cfgError(cfgError)
);

// File: tb/pswDivTop_tb.sv
module pswDivTop_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       vcoTick = 1'b0, refTick = 1'b0, cfgWrite = 1'b0;
  logic [9:0] cfgM = '0;
  logic [5:0] cfgA = '0;
  logic [9:0] cfgR = '0;
  logic       vcoPulse, refPulse, cfgError;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  // bench model state
  int pendM = 63, pendA = 12, pendR = 16;
  int vRem, rRem;
  bit expVco, expRef, expErr;
  string vTag = "R9", rTag = "R7", eTag = "R5";

  always #5 clk = ~clk;

  pswDivTop u_dut (
    .clk(clk), .rstN(rstN), .vcoTick(vcoTick), .refTick(refTick),
    .cfgWrite(cfgWrite), .cfgM(cfgM), .cfgA(cfgA), .cfgR(cfgR),
    .vcoPulse(vcoPulse), .refPulse(refPulse), .cfgError(cfgError)
  );

  function automatic int ratioN(int m, int a);
    return 64 * m + a;
  endfunction

  function automatic int ratioR(int r);
    return (r < 2) ? 1 : r;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // drive one cycle at the falling edge, predict, compare at the next one
  task automatic step(bit vt, bit rt, bit wr, int m, int a, int r);
    bit ok;
    vcoTick = vt; refTick = rt; cfgWrite = wr;
    cfgM = 10'(m); cfgA = 6'(a); cfgR = 10'(r);
    expVco = 0; expRef = 0;
    if (vt) begin
      if (vRem == 1) begin expVco = 1; vRem = ratioN(pendM, pendA); end
      else vRem--;
    end
    if (rt) begin
      if (rRem == 1) begin expRef = 1; rRem = ratioR(pendR); end
      else rRem--;
    end
    if (wr) begin
      ok = (m != 0) && (a <= m);
      expErr = !ok;
      if (ok) begin pendM = m; pendA = a; pendR = r; end
    end
    @(negedge clk);
    check(vTag, "vcoPulse", int'(vcoPulse), int'(expVco));
    check(rTag, "refPulse", int'(refPulse), int'(expRef));
    check(wr ? eTag : "R5 R6", "cfgError", int'(cfgError), int'(expErr));
  endtask

  task automatic run(int n, bit vt, bit rt);
    for (int i = 0; i < n; i++) step(vt, rt, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (5000 * 40) @(posedge clk);
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int cnt;
    void'($urandom(32'd20240611));
    vRem = ratioN(63, 12);
    rRem = 16;
    expErr = 0;
    repeat (3) @(negedge clk);
    // R1: outputs low during reset
    check("R1", "vcoPulse in reset", int'(vcoPulse), 0);
    check("R1", "refPulse in reset", int'(refPulse), 0);
    check("R1", "cfgError in reset", int'(cfgError), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "vcoPulse after reset", int'(vcoPulse), 0);
    check("R1", "cfgError after reset", int'(cfgError), 0);

    // R9: defaults give 4044 and 16, continuous ticks
    vTag = "R9 R3"; rTag = "R9 R7";
    cnt = 0;
    for (int i = 0; i < 4044 * 2; i++) begin
      step(1, 1, 0, 0, 0, 0);
      if (vcoPulse) cnt++;
    end
    check("R9", "pulses in two default periods", cnt, 2);

    // R6 / R8: new values held until reload, R=0 divides by 1
    vTag = "R6"; rTag = "R8"; eTag = "R6";
    run(100, 1, 1);
    step(1, 1, 1, 1, 0, 0);
    run(4200, 1, 1);
    step(1, 1, 1, 2, 0, 1);
    run(300, 1, 1);

    // R10: A equal to M and A zero
    vTag = "R10"; rTag = "R7";
    step(1, 1, 1, 2, 2, 5);
    run(600, 1, 1);
    step(1, 1, 1, 3, 0, 7);
    run(600, 1, 1);

    // R5: rejected writes keep the running settings
    vTag = "R5"; eTag = "R5";
    step(1, 1, 1, 3, 5, 2);
    run(500, 1, 1);
    step(1, 1, 1, 0, 0, 3);
    run(300, 1, 1);
    eTag = "R6";
    step(1, 1, 1, 4, 1, 3);
    run(600, 1, 1);

    // R4: idle cycles must not advance either divider
    vTag = "R4"; rTag = "R4";
    for (int i = 0; i < 2000; i++) step(i % 3 == 0, i % 4 == 1, 0, 0, 0, 0);

    // random phase
    vTag = "R2 R3 R4"; rTag = "R7 R8"; eTag = "R5 R6";
    for (int i = 0; i < 24000; i++) begin
      bit wr;
      int m, a, r;
      wr = ($urandom % 60) == 0;
      m  = $urandom % 6;
      a  = $urandom % 8;
      r  = $urandom % 13;
      step(($urandom % 4) != 0, ($urandom % 2) != 0, wr, m, a, r);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule